// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two wires of an I2C bus and never drives them. Both lines pass through a multi-stage synchronizer; bus conditions and SCL rising edges are then taken from the synchronized level and its one-cycle-old copy. A decoder turns what it sees into a stream of single-cycle event records: start, repeated start, stop, address bytes, data bytes and acknowledge bits. Each record carries a type code, the byte value and the current decoded slave address.

The decoder supports both 7-bit addressing and two-byte 10-bit addressing. It keeps the transfer direction from the first address byte. During the data phase it drops a partly received byte when a START or STOP appears. For every completed transfer it reports two figures with the STOP record: how many bits were sampled and how many clock cycles passed since the most recent START.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After synchronous reset no record is produced and SCL edges and STOP conditions are ignored until a START is seen.
- R2: SDA falling while SCL is high gives a START record (type 1) when no transfer is open. SDA rising while SCL is high in the data phase gives a STOP record (type 3) and closes the transfer.
- R3: A START seen in the data phase before any STOP gives a repeated START record (type 2). After a STOP or a reset the next START is a plain START again.
- R4: Each address and data bit is sampled on an SCL rising edge, most significant bit first. A byte record carries the full received byte on `evt_data`.
- R5: Bit 0 of the first address byte sets the direction: 1 gives address-read (type 6), 0 gives address-write (type 7). Data bytes are data-read (type 8) or data-write (type 9), following that direction until the next START or STOP.
- R6: When the first address byte has bits [7:3] not equal to 11110, the address is 7-bit: `evt_addr` equals the byte shifted right by one and `evt_addr10` is 0.
- R7: When bits [7:3] of the first address byte are 11110, a second address byte follows. Both address records set `evt_addr10`. The first reports address bits [9:8] from its bits [2:1] with the low byte zero; the second reports the full address, whose low byte is the second byte.
- R8: The ninth SCL rising edge after each byte is the acknowledge slot: SDA low gives ACK (type 4), SDA high gives NACK (type 5). Collection then returns to address bytes while any remain, otherwise it enters the data phase.
- R9: The data phase accepts any number of bytes. A START or STOP there ends collection at once, and a partial byte produces no byte record.
- R10: The STOP record carries `xfer_bits`, the address and data bits sampled since the latest START (acknowledge bits excluded, partial bits included). It also carries `xfer_cycles`, the cycle count from the START detection through the STOP detection inclusive.
- R11: `evt_valid` is a one-cycle strobe per event, and every record type is in the range 1 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_type | output | 4 | Event code (1 start, 2 repeated start, 3 stop, 4 ack, 5 nack, 6 addr read, 7 addr write, 8 data read, 9 data write) |
| evt_data | output | 8 | Received byte for byte records, zero otherwise |
| evt_addr | output | 10 | Decoded slave address |
| evt_addr10 | output | 1 | Address is a 10-bit address |
| xfer_bits | output | 16 | Bit count of the last closed transfer |
| xfer_cycles | output | 24 | Cycle count of the last closed transfer |

## Verification
The hardest state to reach is a 10-bit transfer that turns around through a repeated START. Here the header byte must again open a two-byte address and the new direction must hold for the data that follows. The bench drives a 10-bit write, a data byte, then a repeated START into a 10-bit read. It also interrupts the data phase with a STOP after three bits and with a START after two bits, and it resets in the middle of a transfer. Sweeps over every 7-bit address and every data byte value cover the ordinary paths.

// File: rtl/i2c_mon_pkg.sv
// Shared codes for the passive I2C monitor.
// Assumes: one byte on the bus is eight bits, sent most significant first.
package i2c_mon_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int TYPE_W  = 4;

    // Event codes seen on evt_type.
    typedef enum logic [TYPE_W-1:0] {
        EV_NONE    = 4'd0,
        EV_START   = 4'd1,
        EV_RSTART  = 4'd2,
        EV_STOP    = 4'd3,
        EV_ACK     = 4'd4,
        EV_NACK    = 4'd5,
        EV_ADDR_RD = 4'd6,
        EV_ADDR_WR = 4'd7,
        EV_DATA_RD = 4'd8,
        EV_DATA_WR = 4'd9
    } evt_e;

    // Decoder phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_ACK  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;
endpackage

// File: rtl/i2c_mon_sync.sv
// Line synchronizer and bus-condition detector.
// Brings SCL and SDA into the clock domain through STAGES flops each, keeps a
// one-cycle-old copy and derives SCL rise, START and STOP from those two
// registered samples only, so a metastable first stage never reaches them.
// Assumes: idle bus is high, so all flops reset to 1.
module i2c_mon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES  = 2;
    localparam int L_SCL  = 0;
    localparam int L_SDA  = 1;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] pipe_q;
    logic [LINES-1:0]             cur;
    logic [LINES-1:0]             prev_q;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Shift the raw line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q[g] <= '1;
            end else begin
                pipe_q[g] <= {pipe_q[g][STAGES-2:0], raw[g]};
            end
        end
        assign cur[g] = pipe_q[g][STAGES-1];
    end

    // Hold the previous synchronized level of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= cur;
        end
    end

    assign sda_lvl   = cur[L_SDA];
    assign scl_rise  = cur[L_SCL] & ~prev_q[L_SCL];
    assign start_det = cur[L_SCL] & prev_q[L_SCL] & prev_q[L_SDA] & ~cur[L_SDA];
    assign stop_det  = cur[L_SCL] & prev_q[L_SCL] & ~prev_q[L_SDA] & cur[L_SDA];
endmodule

// File: rtl/i2c_mon_decoder.sv
// Transfer decoder for the I2C monitor.
// Walks idle -> address -> acknowledge -> data, assembles bytes MSB first,
// keeps direction and 10-bit address state, and emits one registered record
// per event. START is honoured only in idle or data phase, STOP only in data
// phase; in address and acknowledge phases only SCL rises are looked at.
// Assumes: scl_rise, start_det and stop_det are never high together.
module i2c_mon_decoder
    import i2c_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              acc_start,
    output logic              acc_stop,
    output logic              acc_bit,
    output logic              evt_valid_o,
    output evt_e              evt_type_o,
    output logic [BYTE_W-1:0] evt_data_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic              evt_addr10_o
);
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int LEFT_W = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    phase_e              phase_q;
    logic [IDX_W-1:0]    idx_q;
    logic [BYTE_W-2:0]   shreg_q;
    logic                dir_rd_q;
    logic                open_q;
    logic [LEFT_W-1:0]   addr_left_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                addr10_q;

    logic [BYTE_W-1:0]   nb;
    logic                hdr10;
    logic                byte_done;
    logic [ADDR_W-1:0]   first_addr;
    logic [ADDR_W-1:0]   second_addr;

    // Byte being completed by this rise and its address interpretations.
    always_comb begin
        nb          = {shreg_q, sda_lvl};
        hdr10       = (nb[BYTE_W-1:3] == 5'b11110);
        byte_done   = scl_rise && (idx_q == LAST_IDX);
        first_addr  = hdr10 ? {nb[2:1], {BYTE_W{1'b0}}}
                            : {{(ADDR_W-BYTE_W+1){1'b0}}, nb[BYTE_W-1:1]};
        second_addr = {addr_q[ADDR_W-1 -: HI_W], nb};
    end

    // Accepted conditions, used by the transfer statistics.
    always_comb begin
        acc_start = start_det && (phase_q == PH_IDLE || phase_q == PH_DATA);
        acc_stop  = stop_det && (phase_q == PH_DATA);
        acc_bit   = scl_rise && (phase_q == PH_ADDR || phase_q == PH_DATA);
    end

    // Phase machine, byte assembly and event record register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            idx_q        <= '0;
            shreg_q      <= '0;
            dir_rd_q     <= 1'b0;
            open_q       <= 1'b0;
            addr_left_q  <= '0;
            addr_q       <= '0;
            addr10_q     <= 1'b0;
            evt_valid_o  <= 1'b0;
            evt_type_o   <= EV_NONE;
            evt_data_o   <= '0;
            evt_addr_o   <= '0;
            evt_addr10_o <= 1'b0;
        end else begin
            evt_valid_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_det) begin
                        phase_q      <= PH_ADDR;
                        idx_q        <= '0;
                        addr_left_q  <= '0;
                        open_q       <= 1'b1;
                        evt_valid_o  <= 1'b1;
                        evt_type_o   <= open_q ? EV_RSTART : EV_START;
                        evt_data_o   <= '0;
                        evt_addr_o   <= addr_q;
                        evt_addr10_o <= addr10_q;
                    end
                end
                PH_ADDR: begin
                    if (scl_rise) begin
                        shreg_q <= nb[BYTE_W-2:0];
                        idx_q   <= idx_q + 1'b1;
                        if (byte_done) begin
                            phase_q     <= PH_ACK;
                            evt_valid_o <= 1'b1;
                            evt_data_o  <= nb;
                            if (addr_left_q == '0) begin
                                dir_rd_q     <= nb[0];
                                addr_left_q  <= hdr10 ? 2'd2 : 2'd1;
                                addr_q       <= first_addr;
                                addr10_q     <= hdr10;
                                evt_type_o   <= nb[0] ? EV_ADDR_RD : EV_ADDR_WR;
                                evt_addr_o   <= first_addr;
                                evt_addr10_o <= hdr10;
                            end else begin
                                addr_q       <= second_addr;
                                evt_type_o   <= dir_rd_q ? EV_ADDR_RD : EV_ADDR_WR;
                                evt_addr_o   <= second_addr;
                                evt_addr10_o <= addr10_q;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_rise) begin
                        idx_q        <= '0;
                        evt_valid_o  <= 1'b1;
                        evt_type_o   <= sda_lvl ? EV_NACK : EV_ACK;
                        evt_data_o   <= '0;
                        evt_addr_o   <= addr_q;
                        evt_addr10_o <= addr10_q;
                        if (addr_left_q != '0) begin
                            addr_left_q <= addr_left_q - 1'b1;
                        end
                        phase_q <= (addr_left_q > 2'd1) ? PH_ADDR : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (scl_rise) begin
                        shreg_q <= nb[BYTE_W-2:0];
                        idx_q   <= idx_q + 1'b1;
                        if (byte_done) begin
                            phase_q      <= PH_ACK;
                            evt_valid_o  <= 1'b1;
                            evt_type_o   <= dir_rd_q ? EV_DATA_RD : EV_DATA_WR;
                            evt_data_o   <= nb;
                            evt_addr_o   <= addr_q;
                            evt_addr10_o <= addr10_q;
                        end
                    end else if (start_det) begin
                        phase_q      <= PH_ADDR;
                        idx_q        <= '0;
                        addr_left_q  <= '0;
                        evt_valid_o  <= 1'b1;
                        evt_type_o   <= open_q ? EV_RSTART : EV_START;
                        evt_data_o   <= '0;
                        evt_addr_o   <= addr_q;
                        evt_addr10_o <= addr10_q;
                    end else if (stop_det) begin
                        phase_q      <= PH_IDLE;
                        idx_q        <= '0;
                        open_q       <= 1'b0;
                        dir_rd_q     <= 1'b0;
                        evt_valid_o  <= 1'b1;
                        evt_type_o   <= EV_STOP;
                        evt_data_o   <= '0;
                        evt_addr_o   <= addr_q;
                        evt_addr10_o <= addr10_q;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_mon_stats.sv
// Per-transfer statistics for the I2C monitor.
// Counts sampled address/data bits and elapsed cycles from the latest accepted
// START; on an accepted STOP publishes both, the cycle figure inclusive of the
// START and STOP detection cycles. Counters saturate at their maximum.
// Assumes: acc_start, acc_stop and acc_bit are mutually exclusive.
module i2c_mon_stats #(
    parameter int BITS_W = 16,
    parameter int CYC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_stop,
    input  logic              acc_bit,
    output logic [BITS_W-1:0] xfer_bits_o,
    output logic [CYC_W-1:0]  xfer_cycles_o
);
    localparam logic [BITS_W-1:0] BITS_MAX = '1;
    localparam logic [CYC_W-1:0]  CYC_MAX  = '1;

    logic              active_q;
    logic [BITS_W-1:0] bits_q;
    logic [CYC_W-1:0]  cyc_q;

    // Run the counters while a transfer is open and publish on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q      <= 1'b0;
            bits_q        <= '0;
            cyc_q         <= '0;
            xfer_bits_o   <= '0;
            xfer_cycles_o <= '0;
        end else if (acc_start) begin
            active_q <= 1'b1;
            bits_q   <= '0;
            cyc_q    <= CYC_W'(1);
        end else if (acc_stop) begin
            active_q      <= 1'b0;
            xfer_bits_o   <= bits_q;
            xfer_cycles_o <= (cyc_q == CYC_MAX) ? CYC_MAX : cyc_q + 1'b1;
        end else if (active_q) begin
            if (acc_bit && bits_q != BITS_MAX) begin
                bits_q <= bits_q + 1'b1;
            end
            if (cyc_q != CYC_MAX) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Passive I2C bus monitor, top level.
// Synchronizes the bus lines, decodes transfers into one-cycle event records
// and reports per-transfer bit and cycle counts with each STOP record.
// Assumes: scl_in/sda_in are raw, asynchronous bus levels; nothing is driven.
module i2c_bus_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int BITS_W      = 16,
    parameter int CYC_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              evt_valid,
    output logic [3:0]        evt_type,
    output logic [7:0]        evt_data,
    output logic [9:0]        evt_addr,
    output logic              evt_addr10,
    output logic [BITS_W-1:0] xfer_bits,
    output logic [CYC_W-1:0]  xfer_cycles
);
    import i2c_mon_pkg::*;

    logic sda_lvl, scl_rise, start_det, stop_det;
    logic acc_start, acc_stop, acc_bit;
    evt_e ev_type;

    i2c_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_mon_decoder u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .acc_start    (acc_start),
        .acc_stop     (acc_stop),
        .acc_bit      (acc_bit),
        .evt_valid_o  (evt_valid),
        .evt_type_o   (ev_type),
        .evt_data_o   (evt_data),
        .evt_addr_o   (evt_addr),
        .evt_addr10_o (evt_addr10)
    );

    assign evt_type = ev_type;

    i2c_mon_stats #(.BITS_W(BITS_W), .CYC_W(CYC_W)) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_start     (acc_start),
        .acc_stop      (acc_stop),
        .acc_bit       (acc_bit),
        .xfer_bits_o   (xfer_bits),
        .xfer_cycles_o (xfer_cycles)
    );
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
// Protocol checker for the I2C monitor's record stream, bound to the top.
// Tracks open transfer, pending acknowledge and direction from past records
// and checks each new record against them.
module i2c_bus_monitor_chk #(
    parameter int BITS_W = 16,
    parameter int CYC_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [3:0]        evt_type,
    input logic [7:0]        evt_data,
    input logic [9:0]        evt_addr,
    input logic              evt_addr10,
    input logic [BITS_W-1:0] xfer_bits,
    input logic [CYC_W-1:0]  xfer_cycles
);
    logic open_q, pend_q, rd_q;
    logic is_addr, is_byte;

    assign is_addr = (evt_type == 4'd6) || (evt_type == 4'd7);
    assign is_byte = is_addr || (evt_type == 4'd8) || (evt_type == 4'd9);

    // Follow the record stream to know what may come next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
            rd_q   <= 1'b0;
        end else if (evt_valid) begin
            if (evt_type == 4'd1 || evt_type == 4'd2) open_q <= 1'b1;
            if (evt_type == 4'd3) open_q <= 1'b0;
            if (is_byte) pend_q <= 1'b1;
            if (evt_type == 4'd4 || evt_type == 4'd5) pend_q <= 1'b0;
            if (is_addr) rd_q <= (evt_type == 4'd6);
        end
    end

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_type >= 4'd1 && evt_type <= 4'd9)); // R11
    AST_START_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_type == 4'd1 || evt_type == 4'd2)) |-> ((evt_type == 4'd2) == open_q)); // R3
    AST_STOP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type == 4'd3) |-> open_q); // R2
    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_type == 4'd4 || evt_type == 4'd5)) |-> pend_q); // R8
    AST_BYTE_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && is_byte) |-> !pend_q); // R8
    AST_DATA_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_type == 4'd8 || evt_type == 4'd9)) |-> ((evt_type == 4'd8) == rd_q)); // R5
    AST_ADDR7_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && is_addr && !evt_addr10) |-> (evt_addr == {3'b000, evt_data[7:1]})); // R6
    AST_ADDR10_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && is_addr && evt_addr10) |->
        ((evt_addr[7:0] == evt_data) ||
         (evt_data[7:3] == 5'b11110 && evt_addr == {evt_data[2:1], 8'h00}))); // R7
    AST_STOP_STATS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type == 4'd3) |-> (CYC_W'(xfer_bits) < xfer_cycles)); // R10
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk #(.BITS_W(BITS_W), .CYC_W(CYC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_type    (evt_type),
    .evt_data    (evt_data),
    .evt_addr    (evt_addr),
    .evt_addr10  (evt_addr10),
    .xfer_bits   (xfer_bits),
    .xfer_cycles (xfer_cycles)
);

// File: tb/i2c_bus_monitor_bench.sv
`timescale 1ns/1ps
module i2c_bus_monitor_bench;
    localparam int H     = 4;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        evt_valid;
    logic [3:0]  evt_type;
    logic [7:0]  evt_data;
    logic [9:0]  evt_addr;
    logic        evt_addr10;
    logic [15:0] xfer_bits;
    logic [23:0] xfer_cycles;

    always #2 clk = ~clk;

    i2c_bus_monitor u_i2c_bus_monitor (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .evt_valid(evt_valid), .evt_type(evt_type), .evt_data(evt_data),
        .evt_addr(evt_addr), .evt_addr10(evt_addr10),
        .xfer_bits(xfer_bits), .xfer_cycles(xfer_cycles)
    );

    int vectors = 0;
    int fails = 0;
    int busclk = 0;
    int t_start = 0;
    int exp_wr = 0;
    int ev_rd = 0;
    logic prev_v = 1'b0;

    logic [3:0]  e_type [DEPTH];
    logic [7:0]  e_data [DEPTH];
    logic [9:0]  e_addr [DEPTH];
    logic        e_a10  [DEPTH];
    logic        e_chka [DEPTH];
    logic        e_chks [DEPTH];
    int          e_bits [DEPTH];
    int          e_cyc  [DEPTH];
    string       e_req  [DEPTH];

    task automatic push(input logic [3:0] t, input logic [7:0] d, input logic [9:0] a,
                        input logic a10, input logic chka, input logic chks,
                        input int b, input int c, input string req);
        e_type[exp_wr] = t; e_data[exp_wr] = d; e_addr[exp_wr] = a; e_a10[exp_wr] = a10;
        e_chka[exp_wr] = chka; e_chks[exp_wr] = chks; e_bits[exp_wr] = b; e_cyc[exp_wr] = c;
        e_req[exp_wr] = req;
        exp_wr++;
    endtask

    // Compare each record as it appears against the next expected one.
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            if (prev_v) begin
                fails++;
                $display("FAIL R11 strobe held: actual two cycles expected one");
            end
            vectors++;
            if (ev_rd >= exp_wr) begin
                fails++;
                $display("FAIL R1/R9 unexpected record: actual type %0d data %02h expected none",
                         evt_type, evt_data);
            end else begin
                if (evt_type !== e_type[ev_rd] || evt_data !== e_data[ev_rd] ||
                    (e_chka[ev_rd] && (evt_addr !== e_addr[ev_rd] || evt_addr10 !== e_a10[ev_rd])) ||
                    (e_chks[ev_rd] && (int'(xfer_bits) != e_bits[ev_rd] ||
                                       int'(xfer_cycles) != e_cyc[ev_rd]))) begin
                    fails++;
                    $display("FAIL %s: actual t%0d d%02h a%03h/%0b b%0d c%0d expected t%0d d%02h a%03h/%0b b%0d c%0d",
                             e_req[ev_rd], evt_type, evt_data, evt_addr, evt_addr10, xfer_bits, xfer_cycles,
                             e_type[ev_rd], e_data[ev_rd], e_addr[ev_rd], e_a10[ev_rd],
                             e_bits[ev_rd], e_cyc[ev_rd]);
                end
                ev_rd++;
            end
        end
        prev_v = rst_n && evt_valid;
    end

    task automatic phase(input logic c, input logic d);
        scl_in = c;
        sda_in = d;
        repeat (H) @(negedge clk);
        busclk += H;
    endtask

    task automatic bus_bit(input logic b);
        phase(1'b0, b); phase(1'b1, b); phase(1'b0, b);
    endtask

    task automatic bus_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic bus_start(input logic rep);
        push(rep ? 4'd2 : 4'd1, 8'h00, 10'h0, 1'b0, 1'b0, 1'b0, 0, 0, rep ? "R3" : "R2");
        phase(1'b0, 1'b1); phase(1'b1, 1'b1);
        t_start = busclk;
        phase(1'b1, 1'b0); phase(1'b0, 1'b0);
    endtask

    task automatic bus_stop(input int bits);
        push(4'd3, 8'h00, 10'h0, 1'b0, 1'b0, 1'b1, bits, busclk + 2*H - t_start + 1, "R10");
        phase(1'b0, 1'b0); phase(1'b1, 1'b0); phase(1'b1, 1'b1);
    endtask

    task automatic bus_ack(input logic b, input string req);
        push(b ? 4'd5 : 4'd4, 8'h00, 10'h0, 1'b0, 1'b0, 1'b0, 0, 0, req);
        bus_bit(b);
    endtask

    task automatic exp_byte(input logic [3:0] t, input logic [7:0] d, input logic [9:0] a,
                            input logic a10, input logic chka, input string req);
        push(t, d, a, a10, chka, 1'b0, 0, 0, req);
        bus_byte(d);
    endtask

    // Let records drain, confirm none is missing, then start a fresh list.
    task automatic settle(input string req);
        repeat (20) @(negedge clk);
        vectors++;
        if (ev_rd != exp_wr) begin
            fails++;
            $display("FAIL %s record count: actual %0d expected %0d", req, ev_rd, exp_wr);
        end
        ev_rd = 0;
        exp_wr = 0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog: actual run still busy expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state and idle behaviour.
        repeat (5) @(negedge clk);
        vectors++;
        if (evt_valid !== 1'b0 || xfer_bits !== 16'd0 || xfer_cycles !== 24'd0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual v%0b b%0d c%0d expected 0 0 0",
                     evt_valid, xfer_bits, xfer_cycles);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 9; i++) bus_bit(i[0]);
        phase(1'b0, 1'b0); phase(1'b1, 1'b0); phase(1'b1, 1'b1);
        settle("R1");

        // R2 R4 R5 R6 R8 R10: 7-bit write with two data bytes.
        bus_start(1'b0);
        exp_byte(4'd7, 8'hA0, 10'h050, 1'b0, 1'b1, "R6");
        bus_ack(1'b0, "R8");
        exp_byte(4'd9, 8'h3C, 10'h050, 1'b0, 1'b1, "R5");
        bus_ack(1'b0, "R8");
        exp_byte(4'd9, 8'hC5, 10'h050, 1'b0, 1'b1, "R4");
        bus_ack(1'b1, "R8");
        bus_stop(25);
        settle("R2");

        // R6 R5: every 7-bit address, direction from address bit 0.
        for (int a = 0; a < 128; a++) begin
            if (a[6:2] != 5'b11110) begin
                bus_start(1'b0);
                exp_byte(a[0] ? 4'd6 : 4'd7, {a[6:0], a[0]}, 10'(a), 1'b0, 1'b1, "R6");
                bus_ack(a[1], "R8");
                bus_stop(9);
            end
        end
        settle("R6");

        // R4 R9: read transfer over every data byte value.
        bus_start(1'b0);
        exp_byte(4'd6, 8'h57, 10'h02B, 1'b0, 1'b1, "R5");
        bus_ack(1'b0, "R8");
        for (int v = 0; v < 256; v++) begin
            exp_byte(4'd8, 8'(v), 10'h02B, 1'b0, 1'b1, "R4");
            bus_ack(v[0], "R8");
        end
        bus_stop(8 + 256 * 8 + 1);
        settle("R9");

        // R7 R3: 10-bit write, repeated START into 10-bit read.
        bus_start(1'b0);
        exp_byte(4'd7, 8'hF4, 10'h200, 1'b1, 1'b1, "R7");
        bus_ack(1'b0, "R8");
        exp_byte(4'd7, 8'hA5, 10'h2A5, 1'b1, 1'b1, "R7");
        bus_ack(1'b0, "R8");
        exp_byte(4'd9, 8'h11, 10'h2A5, 1'b1, 1'b1, "R7");
        bus_ack(1'b0, "R8");
        bus_start(1'b1);
        exp_byte(4'd6, 8'hF5, 10'h200, 1'b1, 1'b1, "R7");
        bus_ack(1'b0, "R8");
        exp_byte(4'd6, 8'hA5, 10'h2A5, 1'b1, 1'b1, "R7");
        bus_ack(1'b0, "R8");
        exp_byte(4'd8, 8'h99, 10'h2A5, 1'b1, 1'b1, "R5");
        bus_ack(1'b1, "R8");
        bus_stop(25);
        settle("R7");

        // R9 R10: STOP after three data bits, partial byte dropped.
        bus_start(1'b0);
        exp_byte(4'd7, 8'h20, 10'h010, 1'b0, 1'b1, "R6");
        bus_ack(1'b0, "R8");
        exp_byte(4'd9, 8'hAB, 10'h010, 1'b0, 1'b1, "R9");
        bus_ack(1'b0, "R8");
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_stop(20);
        settle("R9");

        // R9 R3: START after two data bits, then a read and STOP.
        bus_start(1'b0);
        exp_byte(4'd7, 8'h44, 10'h022, 1'b0, 1'b1, "R6");
        bus_ack(1'b0, "R8");
        bus_bit(1'b0); bus_bit(1'b1);
        bus_start(1'b1);
        exp_byte(4'd6, 8'h45, 10'h022, 1'b0, 1'b1, "R5");
        bus_ack(1'b1, "R8");
        bus_stop(9);
        settle("R9");

        // R1 R3: reset inside a transfer, next START is plain.
        bus_start(1'b0);
        exp_byte(4'd7, 8'h66, 10'h033, 1'b0, 1'b1, "R6");
        bus_ack(1'b0, "R8");
        bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
        settle("R1");
        rst_n = 1'b0;
        phase(1'b0, 1'b1); phase(1'b1, 1'b1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_start(1'b0);
        exp_byte(4'd6, 8'h67, 10'h033, 1'b0, 1'b1, "R3");
        bus_ack(1'b0, "R8");
        exp_byte(4'd8, 8'h5A, 10'h033, 1'b0, 1'b1, "R5");
        bus_ack(1'b1, "R8");
        bus_stop(17);
        settle("R3");

        finish_run();
    end
endmodule